// File: doc/BRIEF.md
# Byte-Parity Memory with Error Control Register

This block holds a small word-organised store in which each 16-bit word is kept as 18 bits: two data bytes, each with its own parity bit. A write computes the parity of every byte it touches and stores it beside the data. A read returns the word in the following cycle and checks the stored parity of both bytes.

A failed check always records a sticky error flag. The flag is visible in a control/status register and drives an error indicator output. A bus parity-error line is raised for the failing read's data phase, but only when software has turned reporting on. Write cycles never raise that line.

The store occupies the bottom of an 18-bit byte address space. The control/status register sits at a fixed octal address. Every other address is unmapped.

Top module: `pmem_csr_top`

## Requirements
- R1: The control/status register answers at byte address octal 772100. It reads as bit 15 = error flag, bit 0 = report enable, and all other bits 0. After reset it reads 0, and the outputs `perr_o` and `err_led_o` are 0.
- R2: A write stores the selected bytes, each with a parity bit that gives the byte plus its parity bit an odd number of ones. A read strobed in cycle N returns the stored word on `bus_rdata` in cycle N+1.
- R3: `bus_be[0]` selects bits 7:0 and `bus_be[1]` selects bits 15:8. A write changes only the data and parity of the selected bytes.
- R4: A read fails its check when either byte together with its parity bit holds an even number of ones. After reset the store holds all zeros with zero parity bits, so every never-written byte fails.
- R5: A failed read sets the error flag (bit 15), and the new value is visible from cycle N+1. The flag stays set until a write to the register with `bus_be[1]`=1 and data bit 15 = 0. A write with `bus_be[0]`=1 loads the enable bit from data bit 0.
- R6: `perr_o` is 1 in exactly the cycle after a failing read strobe, and only when the enable bit was 1 at the strobe. Otherwise it is 0.
- R7: A write cycle never raises `perr_o` and never sets the error flag.
- R8: `err_led_o` always equals the error flag.
- R9: Store addresses are bytes 0 to 2*DEPTH-1, and the word index is address bits [IDX_W:1]. A write to any other address that is not the register address has no effect. A read from such an address returns 0 and no error.
- R10: When `bus_rd` and `bus_wr` are both 1, the write is performed and the read is ignored. `bus_rdata` is then 0 in the next cycle.
- R11: In a cycle that does not follow a read strobe, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 18 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_be | input | 2 | Byte lane selects for writes |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| perr_o | output | 1 | Bus parity-error line |
| err_led_o | output | 1 | Error indicator |

## Verification
Directed cases read never-written words with reporting on and with it off. This separates the error flag, which is always recorded, from `perr_o`, which is gated by the enable bit. Half-word writes to a fresh word separate per-byte parity from whole-word parity, because the untouched byte must still fail. Clear attempts with only the low lane selected, unmapped accesses, and simultaneous read and write strobes show what must not change. Seeded random mixes of full and partial writes, reads, register writes and unmapped accesses then test the data path and the flag interplay against a bench model of the store.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_CSR  = 2'd2
    } rsrc_e;

    // parity bit that makes byte plus parity hold an odd count of ones
    function automatic logic odd_fill(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/pmem_array.sv
module pmem_array
    import pmem_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int NB    = DATA_W / BYTE_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [NB-1:0]     be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              fail_now_o,
    output logic              bad_o
);
    typedef struct {
        logic [DATA_W-1:0] data [DEPTH];
        logic [NB-1:0]     par  [DEPTH];
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } arr_st_t;

    arr_st_t s_d, s_q;
    logic    fail_d;

    always_comb begin
        s_d     = s_q;
        s_d.bad = 1'b0;
        fail_d  = 1'b0;
        if (wr_i) begin
            for (int b = 0; b < NB; b++) begin
                if (be_i[b]) begin
                    s_d.data[idx_i][b*BYTE_W +: BYTE_W] = wdata_i[b*BYTE_W +: BYTE_W];
                    s_d.par[idx_i][b] = odd_fill(wdata_i[b*BYTE_W +: BYTE_W]);
                end
            end
        end else if (rd_i) begin
            s_d.rdata = s_q.data[idx_i];
            for (int b = 0; b < NB; b++) begin
                if (^{s_q.par[idx_i][b], s_q.data[idx_i][b*BYTE_W +: BYTE_W]} == 1'b0)
                    fail_d = 1'b1;
            end
            s_d.bad = fail_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                s_q.data[i] <= '0;
                s_q.par[i]  <= '0;
            end
            s_q.rdata <= '0;
            s_q.bad   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o    = s_q.rdata;
    assign fail_now_o = fail_d;
    assign bad_o      = s_q.bad;

    // R7: a write cycle is never followed by a failed-check pulse
    a_r7_write_no_bad: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !bad_o);
    // R2: a fully written word reads back without a check failure
    a_r2_full_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (&be_i)) ##1 (rd_i && !wr_i && $stable(idx_i)) |=> !bad_o);
endmodule

// File: rtl/pmem_csr.sv
module pmem_csr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_i,
    input  logic [1:0]  be_i,
    input  logic [15:0] wdata_i,
    input  logic        fail_now_i,
    input  logic        bad_i,
    output logic [15:0] csr_o,
    output logic        perr_o,
    output logic        led_o
);
    typedef struct packed {
        logic en;
        logic err;
    } csr_st_t;

    csr_st_t c_d, c_q;
    logic    clr_req;

    assign clr_req = we_i && be_i[1] && !wdata_i[15];

    always_comb begin
        c_d = c_q;
        if (fail_now_i)
            c_d.err = 1'b1;
        else if (clr_req)
            c_d.err = 1'b0;
        if (we_i && be_i[0])
            c_d.en = wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign csr_o  = {c_q.err, 14'b0, c_q.en};
    assign perr_o = bad_i && c_q.en;
    assign led_o  = c_q.err;

    // R5: once set, the flag survives anything but a clearing write
    a_r5_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o && !clr_req) |=> led_o);
    // R5: the flag only rises after a failed check
    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_o) |-> $past(fail_now_i));
endmodule

// File: rtl/pmem_csr_top.sv
module pmem_csr_top
    import pmem_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [17:0] CSR_ADDR = 18'o772100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [17:0] bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_be,
    output logic [15:0] bus_rdata,
    output logic        perr_o,
    output logic        err_led_o
);
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int MEM_BYTES = DEPTH * 2;

    logic             in_mem, is_csr, rd_eff;
    logic             mem_wr, mem_rd, csr_we;
    logic [IDX_W-1:0] idx;
    logic [15:0]      mem_rdata, csr_val;
    logic             fail_now, bad;
    rsrc_e            src_d, src_q;

    assign in_mem = (bus_addr < 18'(MEM_BYTES));
    assign is_csr = (bus_addr == CSR_ADDR);
    assign rd_eff = bus_rd && !bus_wr;
    assign mem_wr = bus_wr && in_mem;
    assign mem_rd = rd_eff && in_mem;
    assign csr_we = bus_wr && is_csr;
    assign idx    = bus_addr[IDX_W:1];

    always_comb begin
        src_d = SRC_NONE;
        if (rd_eff) begin
            if (in_mem)      src_d = SRC_MEM;
            else if (is_csr) src_d = SRC_CSR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_NONE;
        else        src_q <= src_d;
    end

    pmem_array #(.DATA_W(16), .DEPTH(DEPTH)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mem_wr),
        .rd_i       (mem_rd),
        .idx_i      (idx),
        .be_i       (bus_be),
        .wdata_i    (bus_wdata),
        .rdata_o    (mem_rdata),
        .fail_now_o (fail_now),
        .bad_o      (bad)
    );

    pmem_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (csr_we),
        .be_i       (bus_be),
        .wdata_i    (bus_wdata),
        .fail_now_i (fail_now),
        .bad_i      (bad),
        .csr_o      (csr_val),
        .perr_o     (perr_o),
        .led_o      (err_led_o)
    );

    always_comb begin
        case (src_q)
            SRC_MEM: bus_rdata = mem_rdata;
            SRC_CSR: bus_rdata = csr_val;
            default: bus_rdata = '0;
        endcase
    end

    // R7: the error line stays low after any write strobe
    a_r7_write_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !perr_o);
    // R6: the error line only follows a read strobe
    a_r6_perr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(bus_rd && !bus_wr));
    // R8: a reported error is also shown on the indicator
    a_r8_led_with_perr: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> err_led_o);
    // R11: no read strobe means the next cycle returns zero data
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 16'h0));
endmodule

// File: tb/pmem_csr_top_tb_top.sv
module pmem_csr_top_tb_top;
    localparam int          DEPTH = 16;
    localparam logic [17:0] CSR_A = 18'o772100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        perr_o, err_led_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_data [DEPTH];
    logic [1:0]  m_par  [DEPTH];
    logic        m_en, m_err;

    always #4 clk = ~clk;

    pmem_csr_top #(.DEPTH(DEPTH), .CSR_ADDR(CSR_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .perr_o(perr_o), .err_led_o(err_led_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic fill(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic word_bad(input int i);
        return (^{m_par[i][0], m_data[i][7:0]} == 1'b0) ||
               (^{m_par[i][1], m_data[i][15:8]} == 1'b0);
    endfunction

    function automatic logic mapped(input logic [17:0] a);
        return a < 18'(2*DEPTH);
    endfunction

    task automatic model_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        int i;
        if (mapped(a)) begin
            i = int'(a[4:1]);
            if (be[0]) begin m_data[i][7:0]  = d[7:0];  m_par[i][0] = fill(d[7:0]);  end
            if (be[1]) begin m_data[i][15:8] = d[15:8]; m_par[i][1] = fill(d[15:8]); end
        end else if (a == CSR_A) begin
            if (be[1] && !d[15]) m_err = 1'b0;
            if (be[0]) m_en = d[0];
        end
    endtask

    task automatic bus_write(input string req, input logic [17:0] a, input logic [15:0] d,
                             input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d, be);
        check({req, " R7 perr after write"}, 32'(perr_o), 32'h0);
        check({req, " R8 led"}, 32'(err_led_o), 32'(m_err));
    endtask

    task automatic bus_read(input string req, input logic [17:0] a);
        logic [15:0] exp_d;
        logic        exp_p;
        logic        bad;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        exp_d = '0; exp_p = 1'b0;
        if (mapped(a)) begin
            exp_d = m_data[int'(a[4:1])];
            bad   = word_bad(int'(a[4:1]));
            exp_p = bad && m_en;
            if (bad) m_err = 1'b1;
        end else if (a == CSR_A) begin
            exp_d = {m_err, 14'b0, m_en};
        end
        check({req, " R2 rdata"}, 32'(bus_rdata), 32'(exp_d));
        check({req, " R6 perr"}, 32'(perr_o), 32'(exp_p));
        check({req, " R5 R8 led"}, 32'(err_led_o), 32'(m_err));
    endtask

    task automatic bus_both(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = 2'b11; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        model_write(a, d, 2'b11);
        check("R10 rdata zero on rd+wr", 32'(bus_rdata), 32'h0);
        check("R10 perr zero on rd+wr", 32'(perr_o), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_par[i] = '0; end
        m_en = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rdata", 32'(bus_rdata), 32'h0);
        check("R1 reset perr", 32'(perr_o), 32'h0);
        check("R1 reset led", 32'(err_led_o), 32'h0);
        check("R11 idle rdata", 32'(bus_rdata), 32'h0);
        bus_read("R1 csr after reset", CSR_A);
        // R4 unwritten word with reporting off: flag but no line
        bus_read("R4 unwritten, enable off", 18'd6);
        check("R5 flag set", 32'(err_led_o), 32'h1);
        bus_read("R1 R5 csr shows flag", CSR_A);
        // R5 low-lane-only write must not clear
        bus_write("R5 low lane no clear", CSR_A, 16'h0000, 2'b01);
        bus_read("R5 still set", CSR_A);
        bus_write("R5 clear", CSR_A, 16'h0000, 2'b10);
        bus_read("R5 cleared", CSR_A);
        // R6 reporting on
        bus_write("R5 enable", CSR_A, 16'h0001, 2'b01);
        bus_read("R6 unwritten, enable on", 18'd10);
        bus_write("R5 clear2", CSR_A, 16'h0001, 2'b11);
        // R2 full word
        bus_write("R2 full", 18'd10, 16'hA55A, 2'b11);
        bus_read("R2 readback clean", 18'd10);
        // R3 byte lanes on a fresh word
        bus_write("R3 low lane", 18'd14, 16'hFF3C, 2'b01);
        bus_read("R3 high byte still bad", 18'd14);
        bus_write("R3 high lane", 18'd15, 16'h7E00, 2'b10);
        bus_read("R3 both lanes good", 18'd14);
        // R9 unmapped
        bus_write("R9 unmapped write", 18'd40, 16'h1234, 2'b11);
        bus_read("R9 unmapped read", 18'd40);
        bus_read("R9 csr unchanged", CSR_A);
        // R10 simultaneous strobes
        bus_both(18'd20, 16'h0F0F);
        bus_read("R10 write took effect", 18'd20);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned op;
            logic [17:0] a;
            op = $urandom % 10;
            a  = (($urandom % 8) == 0) ? 18'(32 + $urandom % 64) : 18'($urandom % (2*DEPTH));
            if (op < 4)
                bus_write("R2 R3 rand write", a, 16'($urandom), 2'($urandom));
            else if (op < 8)
                bus_read("R2 R4 rand read", a);
            else if (op == 8)
                bus_write("R5 rand csr write", CSR_A, 16'($urandom), 2'($urandom));
            else
                bus_read("R1 rand csr read", CSR_A);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule